// File: doc/BRIEF.md
# PCI Read Request Translator

This block sits between a local system bus and a PCI initiator and turns a local read request into a PCI read request. The incoming byte address is compared against a set of address windows. Each window has a local tag, a remote (PCI) tag and a space type, which is either I/O or memory. When a window matches, the high-order address bits are replaced by that window's remote tag and the offset bits below the tag are kept. The two lowest bits are then forced according to the space type. The PCI command is picked from the space type and the request's burst flag. The fixed-length or arbitrary-length qualifier is passed along with the command for the data path to use.

Only one read can be in flight at a time. A control state machine has three states:

- `ST_IDLE`: ready for a request.
- `ST_ISSUE`: the translated request is presented on the PCI side and held until the initiator takes it.
- `ST_WAIT`: the read is outstanding and the block waits for the data path to report completion.

The transitions are:

- `ST_IDLE` to `ST_ISSUE` when a request that hits a window is accepted.
- `ST_IDLE` back to `ST_IDLE` when the request misses every window. An error pulse is raised and no command is issued.
- `ST_ISSUE` to `ST_WAIT` when `pci_ready` is high.
- `ST_WAIT` to `ST_IDLE` when `rd_done` is high.

Top module: `pci_rd_xlate`

## Requirements
- R1: An address whose bits [ADDR_W-1:OFF_W] equal a window's local tag selects that window; if two windows match, the one with the lowest index wins. The defaults are: window 0 has local tag 8'h10, remote tag 8'h80 and memory type; window 1 has 8'h20, 8'hA5 and I/O type; window 2 has 8'h30, 8'hC0 and memory type.
- R2: `pci_addr[ADDR_W-1:OFF_W]` is the selected window's remote tag, and `pci_addr[OFF_W-1:2]` equals `req_addr[OFF_W-1:2]`.
- R3: For a memory window, `pci_addr[1:0]` is 2'b00.
- R4: For an I/O window, `pci_addr[1:0]` equals `req_addr[1:0]`.
- R5: `pci_cmd` follows this mapping:
  - any I/O-window access gives 4'b0010;
  - a memory-window request with `req_burst` low gives 4'b0110;
  - a memory-window request with `req_burst` high gives 4'b1100.
- R6: A request accepted while idle that hits no window raises `xlate_err` for exactly the next cycle. It issues no PCI request, and the block stays idle.
- R7: `busy` is high from the cycle after a hit is accepted until the cycle after `rd_done` is seen in `ST_WAIT`. `req_ready` equals not `busy`, and a request presented while busy is ignored: the outputs are unchanged and nothing is issued afterwards.
- R8: `pci_valid` rises the cycle after a hit is accepted. It stays high, with `pci_addr`, `pci_cmd` and `pci_fixed_len` stable, until a cycle in which `pci_ready` is high, and it is low the following cycle.
- R9: `pci_fixed_len` carries the `req_fixed_len` value captured with the accepted request.
- R10: After reset, `busy`, `pci_valid` and `xlate_err` are low and `req_ready` is high.
- R11: `rd_done` has no effect unless the block is in `ST_WAIT`. In particular, it does not end a request that is still being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local read request strobe |
| req_addr | input | ADDR_W | Local byte address |
| req_burst | input | 1 | Request is a burst |
| req_fixed_len | input | 1 | 1 = fixed-length burst, 0 = arbitrary length |
| req_ready | output | 1 | High when a request can be accepted |
| busy | output | 1 | A read is in flight |
| xlate_err | output | 1 | One-cycle pulse: accepted address hit no window |
| pci_valid | output | 1 | Translated request presented |
| pci_ready | input | 1 | PCI initiator takes the request |
| pci_addr | output | ADDR_W | Translated PCI address |
| pci_cmd | output | 4 | PCI read command code |
| pci_fixed_len | output | 1 | Forwarded length qualifier |
| rd_done | input | 1 | Data path reports the read complete |

## Verification
The assertions check three properties on every cycle:

- the request is held stable while `pci_valid` waits for `pci_ready`;
- memory requests keep their low address bits clear and `pci_cmd` is always one of the three legal codes;
- an error pulse never coincides with busy, and `busy` drops after `rd_done` in `ST_WAIT`.

The bench's scenarios are needed to show the window decode and tag substitution against concrete addresses, and the I/O pass-through of the low bits. They also show that requests made while busy are dropped rather than queued, and that an early `rd_done` during issue is ignored.

// File: rtl/pci_rd_xlate_pkg.sv
package pci_rd_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;

    localparam logic [3:0] CMD_IO_RD       = 4'b0010;
    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;

endpackage

// File: rtl/xl_win_decode.sv
module xl_win_decode #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 24,
    parameter int unsigned NUM_WIN = 3,
    parameter int unsigned TAG_W   = ADDR_W - OFF_W,
    parameter int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    parameter logic [NUM_WIN*TAG_W-1:0] LOCAL_TAGS = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  win_idx
);
    logic [NUM_WIN-1:0] match;

    // One comparator per window
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign match[w] = (addr[ADDR_W-1:OFF_W] == LOCAL_TAGS[w*TAG_W +: TAG_W]);
    end

    // Lowest index wins (R1)
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xl_addr_compose.sv
module xl_addr_compose #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 24,
    parameter int unsigned NUM_WIN = 3,
    parameter int unsigned TAG_W   = ADDR_W - OFF_W,
    parameter int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    parameter logic [NUM_WIN*TAG_W-1:0] REMOTE_TAGS = '0,
    parameter logic [NUM_WIN-1:0]       IO_MASK     = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [ADDR_W-1:0] pci_addr,
    output logic              is_io
);
    logic [TAG_W-1:0] rtag;

    always_comb begin
        rtag     = REMOTE_TAGS[win_idx*TAG_W +: TAG_W];
        is_io    = IO_MASK[win_idx];
        // R2 tag swap, R3/R4 low-bit handling
        pci_addr = {rtag, addr[OFF_W-1:2], (is_io ? addr[1:0] : 2'b00)};
    end
endmodule

// File: rtl/xl_cmd_select.sv
module xl_cmd_select
    import pci_rd_xlate_pkg::*;
(
    input  logic       is_io,
    input  logic       burst,
    output logic [3:0] cmd
);
    // R5 command choice
    always_comb begin
        if (is_io)      cmd = CMD_IO_RD;
        else if (burst) cmd = CMD_MEM_RD_MULT;
        else            cmd = CMD_MEM_RD;
    end
endmodule

// File: rtl/pci_rd_xlate.sv
module pci_rd_xlate
    import pci_rd_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 24,
    parameter int unsigned NUM_WIN = 3,
    parameter logic [NUM_WIN*(ADDR_W-OFF_W)-1:0] LOCAL_TAGS  = {8'h30, 8'h20, 8'h10},
    parameter logic [NUM_WIN*(ADDR_W-OFF_W)-1:0] REMOTE_TAGS = {8'hC0, 8'hA5, 8'h80},
    parameter logic [NUM_WIN-1:0]                IO_MASK     = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_burst,
    input  logic              req_fixed_len,
    output logic              req_ready,
    output logic              busy,
    output logic              xlate_err,
    output logic              pci_valid,
    input  logic              pci_ready,
    output logic [ADDR_W-1:0] pci_addr,
    output logic [3:0]        pci_cmd,
    output logic              pci_fixed_len,
    input  logic              rd_done
);
    localparam int unsigned TAG_W = ADDR_W - OFF_W;
    localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    xl_state_e         state, state_n;
    logic              hit, is_io, accept;
    logic [IDX_W-1:0]  win_idx;
    logic [ADDR_W-1:0] xl_addr;
    logic [3:0]        xl_cmd;
    logic              err_q;

    xl_win_decode #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_WIN(NUM_WIN),
        .TAG_W(TAG_W), .IDX_W(IDX_W), .LOCAL_TAGS(LOCAL_TAGS)
    ) u_dec (
        .addr(req_addr), .hit(hit), .win_idx(win_idx)
    );

    xl_addr_compose #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_WIN(NUM_WIN),
        .TAG_W(TAG_W), .IDX_W(IDX_W),
        .REMOTE_TAGS(REMOTE_TAGS), .IO_MASK(IO_MASK)
    ) u_addr (
        .addr(req_addr), .win_idx(win_idx), .pci_addr(xl_addr), .is_io(is_io)
    );

    xl_cmd_select u_cmd (
        .is_io(is_io), .burst(req_burst), .cmd(xl_cmd)
    );

    assign accept = req_valid && (state == ST_IDLE);

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (accept && hit) state_n = ST_ISSUE;
            ST_ISSUE: if (pci_ready)     state_n = ST_WAIT;
            ST_WAIT:  if (rd_done)       state_n = ST_IDLE;
            default:                     state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Captured request and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_addr      <= '0;
            pci_cmd       <= CMD_MEM_RD;
            pci_fixed_len <= 1'b0;
            err_q         <= 1'b0;
        end else begin
            err_q <= accept && !hit;
            if (accept && hit) begin
                pci_addr      <= xl_addr;
                pci_cmd       <= xl_cmd;
                pci_fixed_len <= req_fixed_len;
            end
        end
    end

    // Outputs from state
    always_comb begin
        busy      = (state != ST_IDLE);
        req_ready = (state == ST_IDLE);
        pci_valid = (state == ST_ISSUE);
        xlate_err = err_q;
    end

    a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && !pci_ready) |=> (pci_valid && $stable(pci_addr) && $stable(pci_cmd) && $stable(pci_fixed_len)))
        else $error("R8 request changed while waiting");

    a_r8_drop_after_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && pci_ready) |=> !pci_valid)
        else $error("R8 valid not dropped");

    a_r3_mem_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && pci_cmd != CMD_IO_RD) |-> (pci_addr[1:0] == 2'b00))
        else $error("R3 memory low bits");

    a_r5_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid |-> (pci_cmd == CMD_IO_RD || pci_cmd == CMD_MEM_RD || pci_cmd == CMD_MEM_RD_MULT))
        else $error("R5 illegal command");

    a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_err |-> (!busy && !pci_valid))
        else $error("R6 error while busy");

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pci_valid && rd_done) |=> !busy)
        else $error("R7 busy not released");

    a_r11_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && !pci_ready) |=> busy)
        else $error("R11 early done released busy");
endmodule

// File: tb/pci_rd_xlate_tb_top.sv
`timescale 1ns/1ps
module pci_rd_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_burst, req_fixed_len, pci_ready, rd_done;
    logic [31:0] req_addr;
    logic        req_ready, busy, xlate_err, pci_valid, pci_fixed_len;
    logic [31:0] pci_addr;
    logic [3:0]  pci_cmd;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference model state: 0 idle, 1 issue, 2 wait
    int          m_st;
    logic [31:0] m_addr;
    logic [3:0]  m_cmd;
    logic        m_fix, m_err;

    always #10 clk = ~clk;

    pci_rd_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_burst(req_burst), .req_fixed_len(req_fixed_len), .req_ready(req_ready),
        .busy(busy), .xlate_err(xlate_err), .pci_valid(pci_valid), .pci_ready(pci_ready),
        .pci_addr(pci_addr), .pci_cmd(pci_cmd), .pci_fixed_len(pci_fixed_len),
        .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Window table, from R1
    function automatic int find_win(input logic [31:0] a);
        if (a[31:24] == 8'h10) return 0;
        if (a[31:24] == 8'h20) return 1;
        if (a[31:24] == 8'h30) return 2;
        return -1;
    endfunction

    task automatic model_step();
        int w;
        logic [7:0] rt;
        logic io;
        m_err = 1'b0;
        case (m_st)
            0: if (req_valid) begin
                w = find_win(req_addr);
                if (w < 0) m_err = 1'b1;
                else begin
                    rt = (w == 0) ? 8'h80 : (w == 1) ? 8'hA5 : 8'hC0;
                    io = (w == 1);
                    m_addr = {rt, req_addr[23:2], io ? req_addr[1:0] : 2'b00};
                    m_cmd  = io ? 4'b0010 : (req_burst ? 4'b1100 : 4'b0110);
                    m_fix  = req_fixed_len;
                    m_st   = 1;
                end
            end
            1: if (pci_ready) m_st = 2;
            default: if (rd_done) m_st = 0;
        endcase
    endtask

    task automatic compare();
        chk(busy == (m_st != 0), "R7 busy", 32'(busy), 32'(m_st != 0));
        chk(req_ready == (m_st == 0), "R7 req_ready", 32'(req_ready), 32'(m_st == 0));
        chk(pci_valid == (m_st == 1), "R8 pci_valid", 32'(pci_valid), 32'(m_st == 1));
        chk(xlate_err == m_err, "R6 xlate_err", 32'(xlate_err), 32'(m_err));
        if (m_st == 1) begin
            chk(pci_addr == m_addr, (m_cmd == 4'b0010) ? "R4 pci_addr" : "R2/R3 pci_addr", pci_addr, m_addr);
            chk(pci_cmd == m_cmd, "R5 pci_cmd", 32'(pci_cmd), 32'(m_cmd));
            chk(pci_fixed_len == m_fix, "R9 pci_fixed_len", 32'(pci_fixed_len), 32'(m_fix));
        end
    endtask

    // Apply inputs after a falling edge, step model, check at the next falling edge
    task automatic cyc(input bit v, input logic [31:0] a, input bit b, input bit f, input bit rdy, input bit dn);
        req_valid = v; req_addr = a; req_burst = b; req_fixed_len = f;
        pci_ready = rdy; rd_done = dn;
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 32'h0, 0, 0, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 0; req_addr = '0; req_burst = 0;
        req_fixed_len = 0; pci_ready = 0; rd_done = 0;
        m_st = 0; m_addr = '0; m_cmd = 4'b0110; m_fix = 0; m_err = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !pci_valid && !xlate_err && req_ready, "R10 reset", {busy, pci_valid, xlate_err, req_ready}, 32'h1);
        rst_n = 1'b1;
        idle(2);

        // R1 window 0, memory single
        cyc(1, 32'h1012_3457, 0, 0, 0, 0);
        chk(pci_addr == 32'h8012_3454, "R1 win0 addr", pci_addr, 32'h8012_3454);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        idle(1);

        // R5 memory burst, fixed length, window 2
        cyc(1, 32'h30AB_CDEF, 1, 1, 0, 0);
        chk(pci_cmd == 4'b1100, "R5 burst cmd", 32'(pci_cmd), 32'hC);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);

        // R4 I/O window, burst flag ignored for command
        cyc(1, 32'h2000_0013, 1, 0, 0, 0);
        chk(pci_addr == 32'hA500_0013, "R4 io addr", pci_addr, 32'hA500_0013);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);

        // R6 miss
        cyc(1, 32'h4000_0000, 0, 0, 0, 0);
        chk(xlate_err == 1'b1, "R6 miss err", 32'(xlate_err), 32'h1);
        idle(1);
        chk(xlate_err == 1'b0 && !pci_valid, "R6 single pulse", 32'(xlate_err), 32'h0);

        // R7 requests while busy dropped; R11 early done ignored
        cyc(1, 32'h1000_0100, 0, 1, 0, 0);
        cyc(1, 32'h3000_0200, 1, 0, 0, 1);
        chk(pci_valid && pci_addr == 32'h8000_0100, "R11 done during issue", pci_addr, 32'h8000_0100);
        cyc(1, 32'h2000_0003, 0, 0, 1, 0);
        cyc(1, 32'h3000_0300, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        idle(2);
        chk(!pci_valid && !busy, "R7 busy request not replayed", 32'(pci_valid), 32'h0);

        // back-to-back accepts after completion, arbitrary-length burst
        cyc(1, 32'h10FF_FFFF, 1, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(1, 32'h2012_3402, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 1);
        idle(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule